// File: doc/BRIEF.md
# Shift-XOR-Add Register Slice

This block is an n-bit accumulator register A with three update operations that take a second operand B: shift A left by one place, replace A with A XOR B, or replace A with A plus B. One control input selects each operation. When no control is high, A keeps its value. A one-bit flag holds the carry out of the most significant bit. Only an add updates this flag, and other cycles leave it unchanged.

Each bit cell contains one sum-style XOR, which serves all three operations. The cell's carry-in line is used in two ways. During a shift it carries the neighbouring lower bit of A. During an add it carries the ripple carry. During an XOR it is tied to zero. The half-sum term A_i XOR B_i is enabled only for XOR and add. A shift therefore reduces to passing the carry-in through. Software or a sequencer drives at most one control per cycle. The bit shifted out of the top is discarded.

Top module: `sxa_reg_slice`

## Requirements
- R1: While rst_ni is low, a_o and carry_o are all zeros.
- R2: In a cycle where shl_i, xor_i and add_i are all 0, a_o keeps its value at the next clock edge.
- R3: With shl_i high, a_o at the next edge becomes the old a_o shifted left by one: bit 0 becomes 0 and the old most significant bit is discarded.
- R4: With xor_i high, a_o at the next edge becomes the bitwise XOR of the old a_o and b_i.
- R5: With add_i high, a_o at the next edge becomes (old a_o + b_i) modulo 2^WIDTH. The carry into bit 0 is 0.
- R6: With add_i high, carry_o at the next edge becomes 1 exactly when old a_o + b_i is at least 2^WIDTH.
- R7: In any cycle where add_i is 0, carry_o keeps its value at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| b_i | input | WIDTH | Operand B |
| shl_i | input | 1 | Shift A left by one |
| xor_i | input | 1 | Load A XOR B |
| add_i | input | 1 | Load A plus B |
| a_o | output | WIDTH | Register A |
| carry_o | output | 1 | Carry out of the last add |

## Verification
Two results fall in the same clock edge on an add cycle: the new sum in A, and the carry flag taken from the same ripple chain. For each control setting, the bench forces every pair of A and B values in a 4-bit configuration. It then applies the operation and compares both outputs at one sample against sums computed arithmetically. Between add cycles, the bench places shift, XOR and hold cycles and confirms that the flag still holds the carry from the last add.

// File: rtl/sxa_pkg.sv
package sxa_pkg;
  typedef struct packed {
    logic shl;   // carry-in takes lower bit of A
    logic add;   // carry-in takes ripple carry
    logic half;  // enable A_i ^ B_i term
    logic load;  // register update enable
  } sxa_ctl_t;
endpackage

// File: rtl/sxa_ctrl.sv
module sxa_ctrl
  import sxa_pkg::*;
(
  input  logic      shl_i,
  input  logic      xor_i,
  input  logic      add_i,
  output sxa_ctl_t  ctl_o
);
  always_comb begin
    ctl_o.shl  = shl_i;
    ctl_o.add  = add_i;
    ctl_o.half = xor_i | add_i;
    ctl_o.load = shl_i | xor_i | add_i;
  end
endmodule

// File: rtl/sxa_cell.sv
module sxa_cell
  import sxa_pkg::*;
(
  input  sxa_ctl_t ctl_i,
  input  logic     a_bit_i,
  input  logic     b_bit_i,
  input  logic     a_low_i,
  input  logic     rc_i,
  output logic     d_o,
  output logic     rc_o
);
  logic prop;
  logic cin;

  assign prop = a_bit_i ^ b_bit_i;
  // shared carry-in: shifted bit, ripple carry, or zero for XOR
  assign cin  = ctl_i.shl ? a_low_i : (ctl_i.add & rc_i);
  assign d_o  = (ctl_i.half & prop) ^ cin;
  assign rc_o = (a_bit_i & b_bit_i) | (prop & rc_i);
endmodule

// File: rtl/sxa_reg_slice.sv
module sxa_reg_slice
  import sxa_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] b_i,
  input  logic             shl_i,
  input  logic             xor_i,
  input  logic             add_i,
  output logic [WIDTH-1:0] a_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  sxa_ctl_t         ctl;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] d;
  logic [WIDTH:0]   rc;
  logic [WIDTH-1:0] a_low;
  logic             carry_q;

  sxa_ctrl i_ctrl (
    .shl_i (shl_i),
    .xor_i (xor_i),
    .add_i (add_i),
    .ctl_o (ctl)
  );

  assign rc[0]    = 1'b0;
  assign a_low[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    if (i > 0) begin : g_low
      assign a_low[i] = a_q[i-1];
    end
    sxa_cell i_cell (
      .ctl_i   (ctl),
      .a_bit_i (a_q[i]),
      .b_bit_i (b_i[i]),
      .a_low_i (a_low[i]),
      .rc_i    (rc[i]),
      .d_o     (d[i]),
      .rc_o    (rc[i+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      carry_q <= 1'b0;
    end else begin
      if (ctl.load) a_q <= d;
      if (ctl.add)  carry_q <= rc[WIDTH];
    end
  end

  assign a_o     = a_q;
  assign carry_o = carry_q;

  logic [WIDTH:0] chk_sum;
  assign chk_sum = {1'b0, a_o} + {1'b0, b_i};

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shl_i | xor_i | add_i) |=> $stable(a_o));
  p_shl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shl_i |=> a_o == {$past(a_o[MSB-1:0]), 1'b0});
  p_xor_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xor_i |=> a_o == ($past(a_o) ^ $past(b_i)));
  p_add_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> a_o == $past(chk_sum[MSB:0]));
  p_carry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |=> carry_o == $past(chk_sum[WIDTH]));
  p_carry_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !add_i |=> $stable(carry_o));
endmodule

// File: tb/test_sxa_reg_slice.sv
`timescale 1ns/1ps
module test_sxa_reg_slice;
  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] b = '0;
  logic         shl = 1'b0, xr = 1'b0, ad = 1'b0;
  logic [W-1:0] a;
  logic         cy;

  int checks = 0, fails = 0;
  int a_m = 0, c_m = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sxa_reg_slice #(.WIDTH(W)) i_sxa_reg_slice (
    .clk_i(clk), .rst_ni(rst_n), .b_i(b), .shl_i(shl), .xor_i(xr),
    .add_i(ad), .a_o(a), .carry_o(cy)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; result sampled at the next negedge
  task automatic apply(input int op, input int bv);
    b   = W'(bv);
    shl = (op == 1);
    xr  = (op == 2);
    ad  = (op == 3);
    @(negedge clk);
    shl = 1'b0; xr = 1'b0; ad = 1'b0;
    case (op)
      1: a_m = (a_m * 2) % N;
      2: a_m = a_m ^ bv;
      3: begin c_m = (a_m + bv) >= N; a_m = (a_m + bv) % N; end
      default: ;
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 a", int'(a), 0);
    chk("R1 carry", int'(cy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int op = 0; op < 4; op++) begin
      for (int av = 0; av < N; av++) begin
        for (int bv = 0; bv < N; bv++) begin
          apply(2, a_m ^ av);   // force A to av
          apply(op, bv);
          case (op)
            0: chk("R2 hold", int'(a), av);
            1: chk("R3 shl", int'(a), (av * 2) % N);
            2: chk("R4 xor", int'(a), av ^ bv);
            default: chk("R5 add", int'(a), (av + bv) % N);
          endcase
          if (op == 3) chk("R6 carry", int'(cy), int'((av + bv) >= N));
          else         chk("R7 carry hold", int'(cy), c_m);
        end
      end
    end
    // carry set, then survive shift/xor/hold
    apply(2, a_m ^ (N - 1));
    apply(3, 1);
    chk("R6 carry wrap", int'(cy), 1);
    chk("R5 wrap", int'(a), 0);
    apply(1, 0);
    apply(2, 3);
    apply(0, 5);
    chk("R7 carry kept", int'(cy), 1);
    chk("R4 after", int'(a), 3);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule